// File: doc/BRIEF.md
# Predicated Branch Resolution Unit

This block settles, for one issued branch, whether it executes and where it goes. A branch may be guarded by one of five condition registers. An invert bit selects the test: the plain test passes when the register is nonzero, and the inverted test passes when it is zero. A branch with no guard always passes.

There are two kinds of branch. A relative branch adds a signed word offset, scaled to bytes, to the current fetch address. An absolute branch takes its full target from a register operand. The block also checks that the branch was issued on a functional unit that is allowed to perform it. When the unit is not allowed, or when the guard selector is a reserved code, it raises an illegal flag and does not take the branch.

Results appear one clock after the issue. Delay slots and the fetch itself are handled elsewhere.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high, and on the first sampling after reset, `taken_o`, `illegal_o` and `target_o` are all zero, whatever the other inputs are.
- R2: Outputs are registered with a latency of one clock. A cycle with `issue_valid_i` low gives `taken_o=0`, `illegal_o=0` and `target_o=0` in the next cycle.
- R3: The guard selector `pred_sel_i` uses the codes 1=A1, 2=A2, 3=B0, 4=B1 and 5=B2. Each code chooses `cond_a1_i`, `cond_a2_i`, `cond_b0_i`, `cond_b1_i` or `cond_b2_i` respectively. With `pred_inv_i=0` the guard is true exactly when the chosen register is nonzero.
- R4: With `pred_inv_i=1` and a selector from 1 to 5, the guard is true exactly when the chosen register equals zero.
- R5: Selector code 0 means unconditional: the guard is always true, and `pred_inv_i` has no effect.
- R6: Selector codes 6 and 7 are reserved. An issue with either code gives `illegal_o=1`, `taken_o=0` and `target_o=0`.
- R7: When `kind_abs_i=0` (relative), the target is `pc_i` plus the 21-bit two's-complement `offset_i`, sign-extended and shifted left by 2. The sum wraps modulo 2^32.
- R8: When `kind_abs_i=1` (absolute), the target is `reg_target_i` unchanged.
- R9: `unit_i` uses the codes 0=L1, 1=S1, 2=M1, 3=D1, 4=L2, 5=S2, 6=M2 and 7=D2. An absolute branch is legal only on code 5. On any other unit it gives `illegal_o=1`, `taken_o=0` and `target_o=0`.
- R10: A relative branch is legal only on an S unit (code 1 or 5). On any other unit it gives `illegal_o=1`, `taken_o=0` and `target_o=0`.
- R11: For a legal issue, `illegal_o=0`, `taken_o` equals the guard, and `target_o` carries the computed target even when the guard is false. `taken_o` and `illegal_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid_i | input | 1 | A branch is issued this cycle |
| cond_a1_i | input | 32 | Condition register A1 |
| cond_a2_i | input | 32 | Condition register A2 |
| cond_b0_i | input | 32 | Condition register B0 |
| cond_b1_i | input | 32 | Condition register B1 |
| cond_b2_i | input | 32 | Condition register B2 |
| pred_sel_i | input | 3 | Guard selector (0 none, 1..5 registers, 6..7 reserved) |
| pred_inv_i | input | 1 | Invert the guard test |
| kind_abs_i | input | 1 | 1 = absolute register branch, 0 = relative |
| unit_i | input | 3 | Issuing functional unit |
| offset_i | input | 21 | Signed word offset for relative branches |
| reg_target_i | input | 32 | Register operand for absolute branches |
| pc_i | input | 32 | Fetch address of the branch |
| taken_o | output | 1 | Branch executes |
| target_o | output | 32 | Resolved target address |
| illegal_o | output | 1 | Branch issued on a disallowed unit or with a reserved selector |

## Verification
The properties assume that every input is a defined value in each cycle it is sampled. They also assume that the unit and selector codes keep the fixed meanings given in R3, R6 and R9, since the legality checks are written directly against those codes. The stimulus draws every field from the full range of its width, reserved codes included. About half of the condition registers are forced to zero, so that both results of the guard occur often. Directed cases cover the extreme offsets, address wrap, and each selector in both polarities.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

    localparam int NUM_CREG = 5;
    localparam int SEL_W    = 3;
    localparam int UNIT_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        PSEL_NONE = 3'd0,
        PSEL_A1   = 3'd1,
        PSEL_A2   = 3'd2,
        PSEL_B0   = 3'd3,
        PSEL_B1   = 3'd4,
        PSEL_B2   = 3'd5,
        PSEL_RSV6 = 3'd6,
        PSEL_RSV7 = 3'd7
    } psel_e;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_L1 = 3'd0,
        UNIT_S1 = 3'd1,
        UNIT_M1 = 3'd2,
        UNIT_D1 = 3'd3,
        UNIT_L2 = 3'd4,
        UNIT_S2 = 3'd5,
        UNIT_M2 = 3'd6,
        UNIT_D2 = 3'd7
    } unit_e;

    typedef enum logic {
        BK_REL = 1'b0,
        BK_ABS = 1'b1
    } bkind_e;

    typedef struct packed {
        logic guard;
        logic illegal;
    } bdec_t;

    function automatic logic is_s_unit(unit_e u);
        return (u == UNIT_S1) || (u == UNIT_S2);
    endfunction

    function automatic logic sel_reserved(psel_e s);
        return (s == PSEL_RSV6) || (s == PSEL_RSV7);
    endfunction

endpackage

// File: rtl/branch_pred_eval.sv
module branch_pred_eval
    import branch_resolve_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_CREG-1:0][DATA_W-1:0] cregs_i,
    input  psel_e                           sel_i,
    input  logic                            inv_i,
    output logic                            guard_o
);

    logic [NUM_CREG-1:0] nonzero;

    genvar g;
    generate
        for (g = 0; g < NUM_CREG; g++) begin : g_nz
            assign nonzero[g] = |cregs_i[g];
        end
    endgenerate

    always_comb begin
        unique case (sel_i)
            PSEL_NONE: guard_o = 1'b1;
            PSEL_A1:   guard_o = nonzero[0] ^ inv_i;
            PSEL_A2:   guard_o = nonzero[1] ^ inv_i;
            PSEL_B0:   guard_o = nonzero[2] ^ inv_i;
            PSEL_B1:   guard_o = nonzero[3] ^ inv_i;
            PSEL_B2:   guard_o = nonzero[4] ^ inv_i;
            default:   guard_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import branch_resolve_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 21
) (
    input  bkind_e             kind_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [ADDR_W-1:0]  reg_i,
    output logic [ADDR_W-1:0]  target_o
);

    localparam int WORD_SH = 2;
    localparam int EXT_W   = ADDR_W - OFF_W - WORD_SH;

    logic [ADDR_W-1:0] byte_disp;

    generate
        if (EXT_W > 0) begin : g_ext
            assign byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SH{1'b0}}};
        end else begin : g_trunc
            assign byte_disp = ADDR_W'({offset_i, {WORD_SH{1'b0}}});
        end
    endgenerate

    always_comb begin
        if (kind_i == BK_ABS) target_o = reg_i;
        else                  target_o = pc_i + byte_disp;
    end

endmodule

// File: rtl/branch_legality.sv
module branch_legality
    import branch_resolve_pkg::*;
#(
    parameter unit_e ABS_UNIT = UNIT_S2
) (
    input  bkind_e kind_i,
    input  unit_e  unit_i,
    input  psel_e  sel_i,
    output logic   illegal_o
);

    logic unit_bad;

    always_comb begin
        if (kind_i == BK_ABS) unit_bad = (unit_i != ABS_UNIT);
        else                  unit_bad = !is_s_unit(unit_i);
        illegal_o = unit_bad || sel_reserved(sel_i);
    end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid_i,
    input  logic [ADDR_W-1:0] cond_a1_i,
    input  logic [ADDR_W-1:0] cond_a2_i,
    input  logic [ADDR_W-1:0] cond_b0_i,
    input  logic [ADDR_W-1:0] cond_b1_i,
    input  logic [ADDR_W-1:0] cond_b2_i,
    input  logic [2:0]        pred_sel_i,
    input  logic              pred_inv_i,
    input  logic              kind_abs_i,
    input  logic [2:0]        unit_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [ADDR_W-1:0] reg_target_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              illegal_o
);

    logic [NUM_CREG-1:0][ADDR_W-1:0] cregs;
    psel_e             sel;
    unit_e             unit;
    bkind_e            kind;
    bdec_t             dec;
    logic [ADDR_W-1:0] tgt;

    assign cregs = {cond_b2_i, cond_b1_i, cond_b0_i, cond_a2_i, cond_a1_i};
    assign sel   = psel_e'(pred_sel_i);
    assign unit  = unit_e'(unit_i);
    assign kind  = bkind_e'(kind_abs_i);

    branch_pred_eval #(.DATA_W(ADDR_W)) u_pred (
        .cregs_i (cregs),
        .sel_i   (sel),
        .inv_i   (pred_inv_i),
        .guard_o (dec.guard)
    );

    branch_legality #(.ABS_UNIT(UNIT_S2)) u_legal (
        .kind_i    (kind),
        .unit_i    (unit),
        .sel_i     (sel),
        .illegal_o (dec.illegal)
    );

    branch_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .reg_i    (reg_target_i),
        .target_o (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o   <= 1'b0;
            illegal_o <= 1'b0;
            target_o  <= '0;
        end else begin
            taken_o   <= issue_valid_i && !dec.illegal && dec.guard;
            illegal_o <= issue_valid_i && dec.illegal;
            target_o  <= (issue_valid_i && !dec.illegal) ? tgt : '0;
        end
    end

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid_i,
    input logic [2:0]        pred_sel_i,
    input logic              kind_abs_i,
    input logic [2:0]        unit_i,
    input logic [ADDR_W-1:0] reg_target_i,
    input logic              taken_o,
    input logic [ADDR_W-1:0] target_o,
    input logic              illegal_o
);

    // R11
    taken_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(taken_o && illegal_o));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid_i |=> (!taken_o && !illegal_o && target_o == '0));

    // R9
    abs_unit_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && kind_abs_i && unit_i != 3'd5) |=> (illegal_o && !taken_o));

    // R8
    abs_target_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && kind_abs_i && unit_i == 3'd5 && pred_sel_i < 3'd6)
        |=> (target_o == $past(reg_target_i)));

    // R5
    uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && pred_sel_i == 3'd0 && kind_abs_i && unit_i == 3'd5) |=> taken_o);

    // R6
    rsv_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && pred_sel_i >= 3'd6) |=> (illegal_o && !taken_o));

endmodule

bind branch_resolve branch_resolve_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_valid_i (issue_valid_i),
    .pred_sel_i    (pred_sel_i),
    .kind_abs_i    (kind_abs_i),
    .unit_i        (unit_i),
    .reg_target_i  (reg_target_i),
    .taken_o       (taken_o),
    .target_o      (target_o),
    .illegal_o     (illegal_o)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid_i = 1'b0;
    logic [31:0] cond_a1_i = '0, cond_a2_i = '0, cond_b0_i = '0, cond_b1_i = '0, cond_b2_i = '0;
    logic [2:0]  pred_sel_i = '0;
    logic        pred_inv_i = 1'b0;
    logic        kind_abs_i = 1'b0;
    logic [2:0]  unit_i = '0;
    logic [20:0] offset_i = '0;
    logic [31:0] reg_target_i = '0;
    logic [31:0] pc_i = '0;
    logic        taken_o;
    logic [31:0] target_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        exp_taken, exp_illegal;
    logic [31:0] exp_target;

    always #4 clk = ~clk;

    branch_resolve uut (
        .clk(clk), .rst(rst), .issue_valid_i(issue_valid_i),
        .cond_a1_i(cond_a1_i), .cond_a2_i(cond_a2_i), .cond_b0_i(cond_b0_i),
        .cond_b1_i(cond_b1_i), .cond_b2_i(cond_b2_i),
        .pred_sel_i(pred_sel_i), .pred_inv_i(pred_inv_i), .kind_abs_i(kind_abs_i),
        .unit_i(unit_i), .offset_i(offset_i), .reg_target_i(reg_target_i), .pc_i(pc_i),
        .taken_o(taken_o), .target_o(target_o), .illegal_o(illegal_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model built from the requirements only.
    task automatic model();
        logic [31:0] r;
        logic        g, bad;
        logic [31:0] t;
        case (pred_sel_i)
            3'd1: r = cond_a1_i;
            3'd2: r = cond_a2_i;
            3'd3: r = cond_b0_i;
            3'd4: r = cond_b1_i;
            3'd5: r = cond_b2_i;
            default: r = '0;
        endcase
        if (pred_sel_i == 3'd0) g = 1'b1;
        else g = pred_inv_i ? (r == 0) : (r != 0);
        if (kind_abs_i) bad = (unit_i != 3'd5);
        else            bad = !(unit_i == 3'd1 || unit_i == 3'd5);
        bad = bad || (pred_sel_i >= 3'd6);
        if (kind_abs_i) t = reg_target_i;
        else            t = pc_i + ({{11{offset_i[20]}}, offset_i} << 2);
        exp_taken   = issue_valid_i && !bad && g;
        exp_illegal = issue_valid_i && bad;
        exp_target  = (issue_valid_i && !bad) ? t : '0;
    endtask

    task automatic step(string t_tag, string i_tag, string g_tag);
        model();
        @(negedge clk);
        chk(t_tag, "taken",   {31'd0, taken_o},   {31'd0, exp_taken});
        chk(i_tag, "illegal", {31'd0, illegal_o}, {31'd0, exp_illegal});
        chk(g_tag, "target",  target_o,           exp_target);
    endtask

    task automatic set_br(logic abs, logic [2:0] u, logic [2:0] s, logic inv);
        issue_valid_i = 1'b1;
        kind_abs_i = abs; unit_i = u; pred_sel_i = s; pred_inv_i = inv;
    endtask

    task automatic set_cregs(logic [2:0] s, logic [31:0] sel_val, logic [31:0] other);
        cond_a1_i = (s == 3'd1) ? sel_val : other;
        cond_a2_i = (s == 3'd2) ? sel_val : other;
        cond_b0_i = (s == 3'd3) ? sel_val : other;
        cond_b1_i = (s == 3'd4) ? sel_val : other;
        cond_b2_i = (s == 3'd5) ? sel_val : other;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset dominates a legal unconditional issue
        set_br(1'b1, 3'd5, 3'd0, 1'b0);
        reg_target_i = 32'hDEAD_BEEC;
        @(negedge clk); @(negedge clk);
        chk("R1", "taken",   {31'd0, taken_o},   32'd0);
        chk("R1", "illegal", {31'd0, illegal_o}, 32'd0);
        chk("R1", "target",  target_o,           32'd0);
        rst = 1'b0;

        // R2: no issue gives quiet outputs
        issue_valid_i = 1'b0;
        step("R2", "R2", "R2");

        // R3/R4: each selector, both polarities, both register values
        for (int s = 1; s <= 5; s++) begin
            reg_target_i = 32'h0000_1000 + 32'(s * 16);
            set_br(1'b1, 3'd5, 3'(s), 1'b0);
            set_cregs(3'(s), 32'h0000_0100, 32'd0);  step("R3", "R3", "R8");
            set_cregs(3'(s), 32'd0, 32'hFFFF_FFFF);  step("R3", "R3", "R8");
            set_br(1'b1, 3'd5, 3'(s), 1'b1);
            set_cregs(3'(s), 32'd0, 32'h8000_0000);  step("R4", "R4", "R8");
            set_cregs(3'(s), 32'h8000_0000, 32'd0);  step("R4", "R4", "R8");
        end

        // R5: unconditional with invert set and all registers zero
        set_cregs(3'd0, 32'd0, 32'd0);
        set_br(1'b1, 3'd5, 3'd0, 1'b1);
        step("R5", "R5", "R8");

        // R6: reserved selectors
        set_cregs(3'd0, 32'd1, 32'd1);
        set_br(1'b1, 3'd5, 3'd6, 1'b0); step("R6", "R6", "R6");
        set_br(1'b0, 3'd1, 3'd7, 1'b1); step("R6", "R6", "R6");

        // R7: offset extremes and wrap
        set_br(1'b0, 3'd1, 3'd0, 1'b0);
        pc_i = 32'h0000_1000; offset_i = 21'h0F_FFFF; step("R7", "R7", "R7");
        pc_i = 32'h0040_0000; offset_i = 21'h10_0000; step("R7", "R7", "R7");
        pc_i = 32'h0000_0000; offset_i = 21'h1F_FFFF; step("R7", "R7", "R7");
        pc_i = 32'hFFFF_FFF0; offset_i = 21'h00_0008; unit_i = 3'd5; step("R7", "R7", "R7");

        // R9: absolute off the permitted unit
        for (int u = 0; u < 8; u++) begin
            set_br(1'b1, 3'(u), 3'd0, 1'b0);
            reg_target_i = 32'h1234_5678;
            step("R9", "R9", "R8");
        end

        // R10: relative on each unit
        for (int u = 0; u < 8; u++) begin
            set_br(1'b0, 3'(u), 3'd0, 1'b0);
            pc_i = 32'h0000_8000; offset_i = 21'd4;
            step("R10", "R10", "R10");
        end

        // R11: guard false still reports target
        set_cregs(3'd0, 32'd0, 32'd0);
        set_br(1'b0, 3'd5, 3'd4, 1'b0);
        pc_i = 32'h0000_2000; offset_i = 21'h1F_FFF0;
        step("R11", "R11", "R11");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            issue_valid_i = ($urandom % 8) != 0;
            cond_a1_i = ($urandom % 2) ? $urandom : 32'd0;
            cond_a2_i = ($urandom % 2) ? $urandom : 32'd0;
            cond_b0_i = ($urandom % 2) ? $urandom : 32'd0;
            cond_b1_i = ($urandom % 2) ? $urandom : 32'd0;
            cond_b2_i = ($urandom % 2) ? $urandom : 32'd0;
            pred_sel_i = 3'($urandom);
            pred_inv_i = 1'($urandom);
            kind_abs_i = 1'($urandom);
            unit_i = ($urandom % 2) ? 3'd5 : 3'($urandom);
            offset_i = 21'($urandom);
            reg_target_i = $urandom;
            pc_i = $urandom;
            step("R11", kind_abs_i ? "R9" : "R10", kind_abs_i ? "R8" : "R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule